// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block turns one configuration-space request into aligned 32-bit transfers on a local memory-mapped bus. A request carries a bus number, device number, function number, byte offset, a length of 1, 2 or 4 bytes, a direction and, for writes, data. The engine first writes an address-window register over the local bus. It then reads and/or writes one configuration dword at an address it builds from the request fields.

On bus 0 the engine issues a Type 0 cycle. The target device is picked by a one-hot select bit. The high part of that select bit goes into the window register and the low part goes into the access address. Any other bus number gives a Type 1 cycle, with the bus, device and function numbers packed into the address.

Read data is aligned down to byte 0 and trimmed to the requested length. Writes of 1 or 2 bytes are done as a read, a lane merge and a write-back. A fault reported by the local bus ends the request with all-ones data and no further transfers. Requests are taken one at a time over a valid/ready handshake. Each request finishes with a one-cycle `rsp_done` strobe and an error code.

Top module: `cfg_access_engine`

## Requirements
- R1: With `req_bus`=0 the window write carries 0x2 OR'd with select bit (dev+16) when that bit is at position 26 or above. The data address is 0x0C000000 \| func<<8 \| (offset with bits 1:0 cleared), plus select bit (dev+16) when it is below position 26.
- R2: With `req_bus`=0, a device number of 16 or more is rejected with `rsp_err`=2'b01 and no local-bus transfer.
- R3: With `req_bus`≠0 the window write carries 0x3. The data address is 0x0C000000 \| bus<<16 \| dev<<11 \| func<<8 \| (offset with bits 1:0 cleared).
- R4: While `cardbus_mode`=1, a device number above 1 is rejected with `rsp_err`=2'b01 and no transfer, on any bus.
- R5: A `req_len` other than 1, 2 or 4 is rejected with `rsp_err`=2'b01 and no transfer.
- R6: A read returns the fetched dword shifted right by 8×(offset mod 4). Only the low `req_len` bytes are kept; the rest are zero. `rsp_err`=2'b00.
- R7: A 1- or 2-byte write reads the dword first. It replaces only the bytes from lane (offset mod 4) upward that fall inside the dword, taking them from the low bytes of `req_wdata`, and writes the result back to the same address.
- R8: A 4-byte write issues only the window write and one data write of `req_wdata`, with no read.
- R9: When `lb_fault` accompanies any accepted transfer, the request ends at once. `rsp_err` is 2'b10, `rsp_rdata` is 0xFFFFFFFF, and no later transfer is issued.
- R10: The window register (address 0x104) is always the first transfer of a request. `req_ready` stays low from acceptance until `rsp_done`. A transfer holds `lb_valid`, `lb_addr` and `lb_write` until `lb_ready`.
- R11: After reset `req_ready`=1, `lb_valid`=0 and `rsp_done`=0. `rsp_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cardbus_mode | input | 1 | Restricts targets to devices 0 and 1; held stable during a request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Byte offset in config space |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 2 | 00 ok, 01 rejected, 10 bus fault |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| lb_valid | output | 1 | Local-bus transfer request |
| lb_write | output | 1 | Local-bus direction |
| lb_addr | output | 32 | Local-bus address |
| lb_wdata | output | 32 | Local-bus write data |
| lb_ready | input | 1 | Transfer accepted this cycle |
| lb_rdata | input | 32 | Read data, valid with lb_ready |
| lb_fault | input | 1 | Transfer faulted, valid with lb_ready |

## Verification
The hardest case to reach is a fault that lands partway through a read-modify-write. The block must then give up after the read and never issue the write-back. A fault after the window write must likewise stop the data transfer. The bench memory model counts transfers within each request and raises a fault on a chosen transfer index. Ready latency also varies from request to request, so every step of the read, merge and write sequence can be hit, including while a transfer is being held.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_WIN,
    ST_RD,
    ST_WR,
    ST_DONE
  } cfg_state_e;

  localparam logic [1:0] ERR_OK    = 2'b00;
  localparam logic [1:0] ERR_REJ   = 2'b01;
  localparam logic [1:0] ERR_FAULT = 2'b10;

  function automatic logic len_legal(input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction

  function automatic logic [31:0] len_mask(input logic [2:0] len);
    case (len)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] dw,
                                               input logic [1:0]  bsel,
                                               input logic [2:0]  len);
    logic [31:0] shifted;
    shifted = dw >> {bsel, 3'b000};
    return shifted & len_mask(len);
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] dw,
                                             input logic [1:0]  bsel,
                                             input logic [2:0]  len,
                                             input logic [31:0] wd);
    logic [31:0] keep;
    logic [31:0] ins;
    keep = len_mask(len) << {bsel, 3'b000};
    ins  = (wd & len_mask(len)) << {bsel, 3'b000};
    return (dw & ~keep) | ins;
  endfunction

endpackage

// File: rtl/cfg_addr_map.sv
module cfg_addr_map #(
  parameter int          BUSW     = 8,
  parameter int          DEVW     = 5,
  parameter int          FUNCW    = 3,
  parameter int          OFFW     = 8,
  parameter int          SLOTS    = 16,
  parameter int          SEL_LSB  = 16,
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [31:0] T0_CODE  = 32'h0000_0002,
  parameter logic [31:0] T1_CODE  = 32'h0000_0003,
  parameter int          BUS_LSB  = 16,
  parameter int          DEV_LSB  = 11,
  parameter int          FUNC_LSB = 8
) (
  input  logic [BUSW-1:0]  bus,
  input  logic [DEVW-1:0]  dev,
  input  logic [FUNCW-1:0] func,
  input  logic [OFFW-1:0]  off,
  input  logic             cardbus,
  output logic             dev_ok,
  output logic [31:0]      win_val,
  output logic [31:0]      data_addr
);

  logic        type1;
  logic [31:0] sel;
  logic [31:0] common;

  assign type1  = (bus != '0);
  // one-hot device select; only meaningful when the device number is legal
  assign sel    = 32'd1 << (32'(dev) + 32'(SEL_LSB));
  assign common = CFG_BASE | (32'(func) << FUNC_LSB) | (32'(off) & ~32'd3);

  always_comb begin
    dev_ok = 1'b1;
    if (cardbus && (32'(dev) > 32'd1)) dev_ok = 1'b0;
    if (!type1 && (32'(dev) >= 32'(SLOTS))) dev_ok = 1'b0;
  end

  always_comb begin
    if (type1) begin
      win_val   = T1_CODE;
      data_addr = common | (32'(bus) << BUS_LSB) | (32'(dev) << DEV_LSB);
    end else begin
      win_val   = T0_CODE | (sel & WIN_MASK);
      data_addr = common | (sel & ~WIN_MASK);
    end
  end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_access_pkg::*;
(
  input  logic [31:0] rd_word,
  input  logic [1:0]  bsel,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic [31:0] rd_aligned,
  output logic [31:0] wr_merged
);

  assign rd_aligned = lane_extract(rd_word, bsel, len);
  assign wr_merged  = lane_merge(rd_word, bsel, len, wdata);

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_access_pkg::*;
#(
  parameter int          BUSW     = 8,
  parameter int          DEVW     = 5,
  parameter int          FUNCW    = 3,
  parameter int          OFFW     = 8,
  parameter logic [31:0] WIN_ADDR = 32'h0000_0104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUSW-1:0]  req_bus,
  input  logic [DEVW-1:0]  req_dev,
  input  logic [FUNCW-1:0] req_func,
  input  logic [OFFW-1:0]  req_off,
  input  logic [2:0]       req_len,
  input  logic [31:0]      req_wdata,
  output logic [BUSW-1:0]  q_bus,
  output logic [DEVW-1:0]  q_dev,
  output logic [FUNCW-1:0] q_func,
  output logic [OFFW-1:0]  q_off,
  output logic [2:0]       q_len,
  output logic [31:0]      q_wdata,
  input  logic             dev_ok,
  input  logic [31:0]      win_val,
  input  logic [31:0]      data_addr,
  input  logic [31:0]      rd_aligned,
  input  logic [31:0]      wr_merged,
  output logic             lb_valid,
  output logic             lb_write,
  output logic [31:0]      lb_addr,
  output logic [31:0]      lb_wdata,
  input  logic             lb_ready,
  input  logic             lb_fault,
  output logic             rsp_done,
  output logic [1:0]       rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             ev_win_done,
  output logic             ev_data_issue,
  output logic             ev_fault
);

  cfg_state_e  state;
  logic        q_write;
  logic [31:0] wr_q;
  logic        beat;
  logic        need_read;

  assign beat      = lb_valid && lb_ready;
  assign need_read = !q_write || (q_len != 3'd4);

  assign req_ready = (state == ST_IDLE);
  assign rsp_done  = (state == ST_DONE);
  assign lb_valid  = (state == ST_WIN) || (state == ST_RD) || (state == ST_WR);
  assign lb_write  = (state == ST_WIN) || (state == ST_WR);
  assign lb_addr   = (state == ST_WIN) ? WIN_ADDR : data_addr;
  assign lb_wdata  = (state == ST_WIN) ? win_val : ((state == ST_WR) ? wr_q : 32'd0);

  assign ev_win_done   = beat && (state == ST_WIN) && !lb_fault;
  assign ev_data_issue = lb_valid && (state != ST_WIN);
  assign ev_fault      = beat && lb_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_write   <= 1'b0;
      q_bus     <= '0;
      q_dev     <= '0;
      q_func    <= '0;
      q_off     <= '0;
      q_len     <= '0;
      q_wdata   <= '0;
      wr_q      <= '0;
      rsp_err   <= ERR_OK;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            q_write   <= req_write;
            q_bus     <= req_bus;
            q_dev     <= req_dev;
            q_func    <= req_func;
            q_off     <= req_off;
            q_len     <= req_len;
            q_wdata   <= req_wdata;
            rsp_err   <= ERR_OK;
            rsp_rdata <= '0;
            state     <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (!dev_ok || !len_legal(q_len)) begin
            rsp_err <= ERR_REJ;
            state   <= ST_DONE;
          end else begin
            state <= ST_WIN;
          end
        end
        ST_WIN: begin
          if (beat) begin
            if (lb_fault) begin
              rsp_err   <= ERR_FAULT;
              rsp_rdata <= '1;
              state     <= ST_DONE;
            end else if (need_read) begin
              state <= ST_RD;
            end else begin
              wr_q  <= q_wdata;
              state <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (beat) begin
            if (lb_fault) begin
              rsp_err   <= ERR_FAULT;
              rsp_rdata <= '1;
              state     <= ST_DONE;
            end else if (!q_write) begin
              rsp_rdata <= rd_aligned;
              state     <= ST_DONE;
            end else begin
              wr_q  <= wr_merged;
              state <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (beat) begin
            if (lb_fault) begin
              rsp_err   <= ERR_FAULT;
              rsp_rdata <= '1;
            end
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
  parameter int          BUSW     = 8,
  parameter int          DEVW     = 5,
  parameter int          FUNCW    = 3,
  parameter int          OFFW     = 8,
  parameter int          SLOTS    = 16,
  parameter logic [31:0] WIN_ADDR = 32'h0000_0104,
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [31:0] T0_CODE  = 32'h0000_0002,
  parameter logic [31:0] T1_CODE  = 32'h0000_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cardbus_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUSW-1:0]  req_bus,
  input  logic [DEVW-1:0]  req_dev,
  input  logic [FUNCW-1:0] req_func,
  input  logic [OFFW-1:0]  req_off,
  input  logic [2:0]       req_len,
  input  logic [31:0]      req_wdata,
  output logic             rsp_done,
  output logic [1:0]       rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             lb_valid,
  output logic             lb_write,
  output logic [31:0]      lb_addr,
  output logic [31:0]      lb_wdata,
  input  logic             lb_ready,
  input  logic [31:0]      lb_rdata,
  input  logic             lb_fault
);

  logic [BUSW-1:0]  q_bus;
  logic [DEVW-1:0]  q_dev;
  logic [FUNCW-1:0] q_func;
  logic [OFFW-1:0]  q_off;
  logic [2:0]       q_len;
  logic [31:0]      q_wdata;
  logic             dev_ok;
  logic [31:0]      win_val;
  logic [31:0]      data_addr;
  logic [31:0]      rd_aligned;
  logic [31:0]      wr_merged;
  logic             ev_win_done;
  logic             ev_data_issue;
  logic             ev_fault;

  cfg_addr_map #(
    .BUSW(BUSW), .DEVW(DEVW), .FUNCW(FUNCW), .OFFW(OFFW), .SLOTS(SLOTS),
    .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK), .T0_CODE(T0_CODE), .T1_CODE(T1_CODE)
  ) u_map (
    .bus(q_bus), .dev(q_dev), .func(q_func), .off(q_off), .cardbus(cardbus_mode),
    .dev_ok(dev_ok), .win_val(win_val), .data_addr(data_addr)
  );

  cfg_lane_unit u_lane (
    .rd_word(lb_rdata), .bsel(q_off[1:0]), .len(q_len), .wdata(q_wdata),
    .rd_aligned(rd_aligned), .wr_merged(wr_merged)
  );

  cfg_seq #(
    .BUSW(BUSW), .DEVW(DEVW), .FUNCW(FUNCW), .OFFW(OFFW), .WIN_ADDR(WIN_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_len(req_len), .req_wdata(req_wdata),
    .q_bus(q_bus), .q_dev(q_dev), .q_func(q_func), .q_off(q_off), .q_len(q_len),
    .q_wdata(q_wdata),
    .dev_ok(dev_ok), .win_val(win_val), .data_addr(data_addr),
    .rd_aligned(rd_aligned), .wr_merged(wr_merged),
    .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_ready(lb_ready), .lb_fault(lb_fault),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ev_win_done(ev_win_done), .ev_data_issue(ev_data_issue), .ev_fault(ev_fault)
  );

endmodule

// File: rtl/cfg_access_checker.sv
module cfg_access_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        lb_valid,
  input logic        lb_ready,
  input logic        lb_write,
  input logic [31:0] lb_addr,
  input logic        rsp_done,
  input logic [1:0]  rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        ev_win_done,
  input logic        ev_data_issue,
  input logic        ev_fault
);

  logic win_seen;
  logic acc_seen;
  logic fault_seen;
  logic accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_seen   <= 1'b0;
      acc_seen   <= 1'b0;
      fault_seen <= 1'b0;
    end else begin
      if (rsp_done) win_seen <= 1'b0;
      else if (ev_win_done) win_seen <= 1'b1;
      if (accept) acc_seen <= 1'b0;
      else if (lb_valid) acc_seen <= 1'b1;
      if (accept) fault_seen <= 1'b0;
      else if (ev_fault) fault_seen <= 1'b1;
    end
  end

  a_r10_window_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_issue |-> win_seen);

  a_r10_hold_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_addr) && $stable(lb_write)));

  a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid |-> !req_ready);

  a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err == 2'b01) |-> !acc_seen);

  a_r9_fault_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err == 2'b10) |-> (rsp_rdata == 32'hFFFF_FFFF));

  a_r9_stop_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid |-> !fault_seen);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind cfg_access_engine cfg_access_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_write(lb_write), .lb_addr(lb_addr),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .ev_win_done(ev_win_done), .ev_data_issue(ev_data_issue), .ev_fault(ev_fault)
);

// File: tb/cfg_access_engine_tb.sv
module cfg_access_engine_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] WINA = 32'h0000_0104;
  localparam logic [31:0] BASE = 32'h0C00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cardbus_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [1:0]  rsp_err;
  logic [31:0] rsp_rdata;
  logic        lb_valid, lb_write, lb_ready, lb_fault;
  logic [31:0] lb_addr, lb_wdata, lb_rdata;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_access_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_len(req_len), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_ready(lb_ready), .lb_rdata(lb_rdata), .lb_fault(lb_fault)
  );

  // memory model: content is a hash of the address, faults on a chosen transfer
  function automatic logic [31:0] patt(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h6C8E_9CF5;
  endfunction

  int          lat = 0;
  int          fault_at = -1;
  logic        log_clr = 1'b0;
  int          wc = 0;
  int          txn, wins, rds, wrs;
  logic        first_win;
  logic [31:0] win_v, rd_a, wr_a, wr_d;

  assign lb_ready = lb_valid && (wc >= lat);
  assign lb_fault = lb_valid && lb_ready && (txn == fault_at);
  assign lb_rdata = lb_write ? 32'd0 : patt(lb_addr);

  always @(posedge clk) begin
    if (!lb_valid || lb_ready) wc <= 0;
    else wc <= wc + 1;
    if (log_clr) begin
      txn <= 0; wins <= 0; rds <= 0; wrs <= 0; first_win <= 1'b0;
      win_v <= '0; rd_a <= '0; wr_a <= '0; wr_d <= '0;
    end else if (lb_valid && lb_ready) begin
      if (txn == 0) first_win <= lb_write && (lb_addr == WINA);
      if (lb_write && lb_addr == WINA) begin
        wins <= wins + 1; win_v <= lb_wdata;
      end else if (lb_write) begin
        wrs <= wrs + 1; wr_a <= lb_addr; wr_d <= lb_wdata;
      end else begin
        rds <= rds + 1; rd_a <= lb_addr;
      end
      txn <= txn + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void exp_map(input int bus, input int dev, input int func, input int off,
                                  output logic [31:0] w, output logic [31:0] a);
    int pos;
    a = BASE | (32'(func) << 8) | (32'(off) & 32'hFFFF_FFFC);
    if (bus == 0) begin
      pos = dev + 16;
      w = 32'h2;
      if (pos >= 26) w = w | (32'd1 << pos);
      else a = a | (32'd1 << pos);
    end else begin
      w = 32'h3;
      a = a | (32'(bus) << 16) | (32'(dev) << 11);
    end
  endfunction

  function automatic logic [31:0] exp_extract(input logic [31:0] v, input int off, input int len);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int src = (off % 4) + k;
      if (k < len && src < 4) r[8*k +: 8] = v[8*src +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_merge(input logic [31:0] v, input int off, input int len,
                                            input logic [31:0] wd);
    logic [31:0] r = v;
    for (int k = 0; k < len; k++) begin
      int dst = (off % 4) + k;
      if (dst < 4) r[8*dst +: 8] = wd[8*k +: 8];
    end
    return r;
  endfunction

  task automatic run_req(input string req, input logic wr, input int bus, input int dev,
                         input int func, input int off, input int len,
                         input logic [31:0] wd, input logic cb, input int fa);
    logic        legal;
    logic [31:0] ew, ea, old;
    int          n;
    int          wr_idx;
    legal = (len == 1 || len == 2 || len == 4) && !(cb && dev > 1) && !(bus == 0 && dev >= 16);
    exp_map(bus, dev, func, off, ew, ea);
    old = patt(ea);
    @(negedge clk);
    log_clr = 1'b1; fault_at = fa; cardbus_mode = cb; lat = (tests % 3);
    @(negedge clk);
    log_clr = 1'b0;
    req_valid = 1'b1; req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev);
    req_func = 3'(func); req_off = 8'(off); req_len = 3'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R10 busy"}, 32'(req_ready), 32'd0);
    n = 0;
    while (!rsp_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({req, " R10 completes"}, 32'(rsp_done), 32'd1);
    if (!legal) begin
      chk({req, " reject code"}, 32'(rsp_err), 32'd1);
      chk({req, " reject no transfer"}, 32'(txn), 32'd0);
    end else if (fa >= 0) begin
      wr_idx = (!wr || len != 4) ? 2 : 1;
      chk({req, " R9 fault code"}, 32'(rsp_err), 32'd2);
      chk({req, " R9 all ones"}, rsp_rdata, 32'hFFFF_FFFF);
      chk({req, " R9 stops"}, 32'(txn), 32'(fa + 1));
      if (fa < wr_idx) chk({req, " R9 no write"}, 32'(wrs), 32'd0);
    end else begin
      chk({req, " R10 window first"}, 32'(first_win), 32'd1);
      chk({req, " window value"}, win_v, ew);
      chk({req, " ok code"}, 32'(rsp_err), 32'd0);
      if (!wr) begin
        chk({req, " read addr"}, rd_a, ea);
        chk({req, " R6 data"}, rsp_rdata, exp_extract(old, off, len));
      end else if (len == 4) begin
        chk({req, " R8 no read"}, 32'(rds), 32'd0);
        chk({req, " R8 write addr"}, wr_a, ea);
        chk({req, " R8 write data"}, wr_d, wd);
      end else begin
        chk({req, " R7 read addr"}, rd_a, ea);
        chk({req, " R7 write addr"}, wr_a, ea);
        chk({req, " R7 merged"}, wr_d, exp_merge(old, off, len, wd));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 ready at reset", 32'(req_ready), 32'd1);
    chk("R11 no transfer at reset", 32'(lb_valid), 32'd0);
    chk("R11 no done at reset", 32'(rsp_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R6: Type 0 reads over every legal device, offset and length
    for (int d = 0; d < 16; d++)
      for (int o = 0; o < 8; o++)
        for (int l = 1; l <= 4; l = l * 2)
          run_req("R1", 1'b0, 0, d, d % 8, o * 5 + 64, l, 32'd0, 1'b0, -1);

    // R2: Type 0 device out of range
    for (int d = 16; d < 32; d++)
      run_req("R2", 1'b0, 0, d, 1, 4, 4, 32'd0, 1'b0, -1);

    // R3: Type 1 address packing
    for (int b = 0; b < 3; b++)
      for (int d = 0; d < 3; d++)
        for (int f = 0; f < 3; f++) begin
          int bus_v = (b == 0) ? 1 : ((b == 1) ? 7 : 255);
          int dev_v = (d == 0) ? 0 : ((d == 1) ? 9 : 31);
          int fun_v = (f == 0) ? 0 : ((f == 1) ? 3 : 7);
          run_req("R3", 1'b0, bus_v, dev_v, fun_v, 5 + f * 100, 2, 32'd0, 1'b0, -1);
          run_req("R3", 1'b0, bus_v, dev_v, fun_v, 252, 4, 32'd0, 1'b0, -1);
        end

    // R7: partial writes, every lane position
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 8; o++)
        for (int l = 1; l <= 2; l++)
          run_req("R7", 1'b1, b * 2, 3 + b * 9, 2, 16 + o, l,
                  32'hC3A5_0000 | 32'(o * 17 + l), 1'b0, -1);

    // R8: full-dword writes
    for (int d = 0; d < 16; d++) begin
      run_req("R8", 1'b1, 0, d, 0, d * 4, 4, 32'hDEAD_0000 + 32'(d), 1'b0, -1);
      run_req("R8", 1'b1, 3, d, 6, 60, 4, 32'h1234_5600 + 32'(d), 1'b0, -1);
    end

    // R5: illegal lengths for reads and writes
    for (int l = 0; l < 8; l++)
      if (l != 1 && l != 2 && l != 4) begin
        run_req("R5", 1'b0, 0, 2, 0, 8, l, 32'd0, 1'b0, -1);
        run_req("R5", 1'b1, 2, 2, 0, 8, l, 32'hFFFF_FFFF, 1'b0, -1);
      end

    // R4: restricted device range
    for (int d = 0; d < 6; d++) begin
      run_req("R4", 1'b0, 0, d, 0, 12, 4, 32'd0, 1'b1, -1);
      run_req("R4", 1'b0, 4, d, 1, 12, 1, 32'd0, 1'b1, -1);
    end

    // R9: faults at each step of each sequence
    for (int fa = 0; fa < 2; fa++)
      run_req("R9 read", 1'b0, 0, 5, 1, 6, 2, 32'd0, 1'b0, fa);
    for (int fa = 0; fa < 3; fa++)
      run_req("R9 rmw", 1'b1, 0, 12, 2, 7, 1, 32'h0000_00AB, 1'b0, fa);
    for (int fa = 0; fa < 2; fa++)
      run_req("R9 full", 1'b1, 9, 4, 3, 40, 4, 32'h0BAD_F00D, 1'b0, fa);

    // back to normal after faults
    run_req("R6 after fault", 1'b0, 0, 1, 0, 3, 1, 32'd0, 1'b0, -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule